// File: doc/BRIEF.md
# Digit-Serial Complex Postscale Multiplier

This block multiplies a stream of complex digits, most significant first, by a complex factor that stays fixed for the whole operation. Each digit pair (dr, di) lies in {-A..A}. The factor (cr, ci) is given in fixed point with CF fraction bits, lies in [-1, 1), and is already divided by the radix r = 2^LOG_R. For each accepted digit pair the block emits one real and one imaginary signed result digit. The result is never assembled in a carry-propagate adder.

Internally there are four sequential multiply lanes. Each lane accumulates one partial product term: +cr·dr, -ci·di, +ci·dr and +cr·di. A lane keeps the fractional part of its running sum, scaled by r, and passes the integer part out as a raw digit. This raw digit can exceed one radix digit.

A per-lane recoder then splits each raw digit into a transfer and a residue. The transfer goes one position up, and the recoded digit is the residue plus the transfer arriving from the next less significant position. A second transfer stage adds the two recoded real digits, and likewise the two recoded imaginary digits, so that each result digit fits in {-(r-1)..r-1}.

A two-state controller governs operation:
- **IDLE**: the state after reset. Digit strobes are ignored.
- **RUN**: digits are accepted.
- The transition IDLE→RUN is taken on `start`.
- In RUN, `start` keeps the state at RUN. It reloads the factor and clears every lane, recoder and adder, so the operation restarts.

Top module: `csqrt_postscale`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is low and both output digits are zero; the controller is in IDLE.
- R2: Until the first `start` after reset, `dig_valid` pulses produce no output: `out_valid` stays low.
- R3: A digit pair is accepted when `dig_valid` is high, the controller is in RUN and `start` is low. Each accepted pair yields exactly one output pair, with `out_valid` high exactly three cycles after the acceptance cycle.
- R4: Every output digit is a two's-complement value of LOG_R+1 bits in {-(r-1)..r-1}.
- R5: Number the output digits of an operation k = 0, 1, … and give digit k the weight r^(1-k). After N accepted pairs, the real digits sum to within r^-(N-2) of cr·XR − ci·XI. Here XR = Σ dr_k·r^-k and XI = Σ di_k·r^-k, with the first input digit at k = 1, and factor values are cr/2^CF and ci/2^CF.
- R6: Under the same weighting and bound, the imaginary digits sum to cr·XI + ci·XR.
- R7: `start` loads the new factor and clears all accumulated state. Outputs of digits accepted before it that have not yet appeared are dropped, and the next operation's result is unaffected by them.
- R8: Cycles with `dig_valid` low between accepted pairs do not change the result value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load factor, clear state, enter RUN |
| cr_in | input | CF+1 | Real part of the factor, signed, CF fraction bits |
| ci_in | input | CF+1 | Imaginary part of the factor, signed, CF fraction bits |
| dig_valid | input | 1 | Digit pair strobe |
| dig_re | input | clog2(A+1)+1 | Real input digit, signed |
| dig_im | input | clog2(A+1)+1 | Imaginary input digit, signed |
| out_valid | output | 1 | Result digit pair valid |
| out_re | output | LOG_R+1 | Real result digit, signed |
| out_im | output | LOG_R+1 | Imaginary result digit, signed |

## Verification
A corrupted lane remainder shows up in the output digit stream one to three positions later. Because the remainder is carried forward, the error persists and drives the reconstructed value far outside the bound at the end of the operation. A wrong transfer in a recoder or adder moves weight by one radix position. This gives a value error of order r^-k at that position, and it may also push a digit out of range as soon as it is emitted. State that leaks across `start`, or a stage that advances without a strobe, corrupts the first digits of the following operation or breaks the three-cycle spacing on the very next output.

// File: rtl/pscl_pkg.sv
package pscl_pkg;

    typedef enum logic [0:0] {
        PS_IDLE = 1'b0,
        PS_RUN  = 1'b1
    } pscl_state_e;

    // Transfer to the next more significant position: +1, -1 or 0
    function automatic logic signed [1:0] xfer_dir(input int v, input int half);
        if (v >= half)
            return 2'sd1;
        else if (v <= -half)
            return -2'sd1;
        else
            return 2'sd0;
    endfunction

endpackage

// File: rtl/pscl_lane.sv
module pscl_lane #(
    parameter int LOG_R = 2,
    parameter int A     = 3,
    parameter int CF    = 12,
    parameter bit NEG   = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      in_valid,
    input  logic signed [CF:0]        coef,
    input  logic signed [$clog2(A+1):0] dig,
    output logic                      out_valid,
    output logic signed [LOG_R+1:0]   raw
);
    localparam int R  = 1 << LOG_R;
    localparam int CW = CF + 1;
    localparam int SW = $clog2(A + 1) + 1;
    localparam int RW = LOG_R + 2;
    localparam int UW = CF + LOG_R;
    localparam int TW = CF + RW;

    logic        [UW-1:0] u_q;
    logic signed [TW-1:0] cx, sx, prod, term, t;

    assign cx   = {{(TW-CW){coef[CW-1]}}, coef};
    assign sx   = {{(TW-SW){dig[SW-1]}}, dig};
    assign prod = cx * sx;

    generate
        if (NEG) begin : g_sub
            assign term = -prod;
        end else begin : g_add
            assign term = prod;
        end
    endgenerate

    assign t = $signed({2'b00, u_q}) + term;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            u_q       <= '0;
            raw       <= '0;
            out_valid <= 1'b0;
        end else if (in_valid) begin
            u_q       <= {t[CF-1:0], {LOG_R{1'b0}}};
            raw       <= t[TW-1:CF];
            out_valid <= 1'b1;
        end else begin
            out_valid <= 1'b0;
        end
    end

    // R5: raw lane digit stays inside the over-redundant set {-A..r+A-1}
    p_raw_range_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(raw) >= -A && int'(raw) <= R + A - 1));

endmodule

// File: rtl/pscl_xfer.sv
module pscl_xfer #(
    parameter int LOG_R = 2,
    parameter int IW    = 4,
    parameter int NIN   = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   in_valid,
    input  logic [NIN*IW-1:0]      din,
    output logic                   out_valid,
    output logic signed [LOG_R:0]  dout
);
    import pscl_pkg::*;

    localparam int R    = 1 << LOG_R;
    localparam int HALF = R / 2;
    localparam int OW   = LOG_R + 1;
    localparam int SUMW = IW + 2;

    logic signed [SUMW-1:0] sum, w;
    logic signed [1:0]      tr;
    logic signed [OW-1:0]   pend_q;

    always_comb begin
        sum = '0;
        for (int k = 0; k < NIN; k++) begin
            sum = sum + {{(SUMW-IW){din[k*IW+IW-1]}}, din[k*IW +: IW]};
        end
        tr = xfer_dir(int'(sum), HALF);
        unique case (tr)
            2'sd1:   w = sum - SUMW'(R);
            -2'sd1:  w = sum + SUMW'(R);
            default: w = sum;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend_q    <= '0;
            dout      <= '0;
            out_valid <= 1'b0;
        end else if (in_valid) begin
            dout      <= pend_q + {{(OW-2){tr[1]}}, tr};
            pend_q    <= w[OW-1:0];
            out_valid <= 1'b1;
        end else begin
            out_valid <= 1'b0;
        end
    end

    // R4: emitted digit stays inside {-(r-1)..r-1}
    p_digit_range_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(dout) >= -(R - 1) && int'(dout) <= R - 1));

    // R4: residue left behind leaves room for an incoming unit transfer
    p_residue_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (int'(w) >= -(R - 2) && int'(w) <= R - 2));

endmodule

// File: rtl/csqrt_postscale.sv
module csqrt_postscale #(
    parameter  int LOG_R = 2,
    parameter  int A     = 3,
    parameter  int CF    = 12,
    localparam int CW    = CF + 1,
    localparam int SW    = $clog2(A + 1) + 1,
    localparam int OW    = LOG_R + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic signed [CW-1:0] cr_in,
    input  logic signed [CW-1:0] ci_in,
    input  logic                 dig_valid,
    input  logic signed [SW-1:0] dig_re,
    input  logic signed [SW-1:0] dig_im,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_re,
    output logic signed [OW-1:0] out_im
);
    import pscl_pkg::*;

    localparam int NLANE = 4;
    localparam int RW    = LOG_R + 2;

    pscl_state_e          state_q, state_d;
    logic                 accept, clr;
    logic signed [CW-1:0] cr_q, ci_q;

    logic [NLANE-1:0]     lane_v, rec_v;
    logic [1:0]           add_v;
    logic signed [RW-1:0] lane_d [NLANE];
    logic signed [OW-1:0] rec_d  [NLANE];
    logic signed [OW-1:0] add_d  [2];

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: if (start) state_d = PS_RUN;
            PS_RUN:  state_d = PS_RUN;
        endcase
    end

    // Controller outputs
    always_comb begin
        clr    = start;
        accept = (state_q == PS_RUN) && dig_valid && !start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cr_q <= '0;
            ci_q <= '0;
        end else if (start) begin
            cr_q <= cr_in;
            ci_q <= ci_in;
        end
    end

    // Lane i: 0 = +cr*dr, 1 = -ci*di, 2 = +ci*dr, 3 = +cr*di
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        localparam bit USE_CR = (i == 0) || (i == 3);
        localparam bit USE_RE = (i == 0) || (i == 2);
        localparam bit IS_NEG = (i == 1);

        pscl_lane #(.LOG_R(LOG_R), .A(A), .CF(CF), .NEG(IS_NEG)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .clr       (clr),
            .in_valid  (accept),
            .coef      (USE_CR ? cr_q : ci_q),
            .dig       (USE_RE ? dig_re : dig_im),
            .out_valid (lane_v[i]),
            .raw       (lane_d[i])
        );

        pscl_xfer #(.LOG_R(LOG_R), .IW(RW), .NIN(1)) u_rec (
            .clk       (clk),
            .rst       (rst),
            .clr       (clr),
            .in_valid  (lane_v[i]),
            .din       (lane_d[i]),
            .out_valid (rec_v[i]),
            .dout      (rec_d[i])
        );
    end

    // Pairwise adders: 0 = real (lanes 0,1), 1 = imaginary (lanes 2,3)
    for (genvar k = 0; k < 2; k++) begin : g_add
        pscl_xfer #(.LOG_R(LOG_R), .IW(OW), .NIN(2)) u_add (
            .clk       (clk),
            .rst       (rst),
            .clr       (clr),
            .in_valid  (rec_v[2*k]),
            .din       ({rec_d[2*k+1], rec_d[2*k]}),
            .out_valid (add_v[k]),
            .dout      (add_d[k])
        );
    end

    assign out_valid = add_v[0];
    assign out_re    = add_d[0];
    assign out_im    = add_d[1];

    // R3: every result digit traces back to an acceptance three cycles earlier
    p_latency_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(accept, 3));

    // R3: all lanes, recoders and adders step together
    p_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        (lane_v == '0 || lane_v == '1) && (rec_v == '0 || rec_v == '1) &&
        (add_v == 2'b00 || add_v == 2'b11));

    // R2: nothing leaves the block before the first start
    p_idle_silent_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_IDLE) |-> !out_valid);

    // R7: start flushes every stage
    p_flush_r7: assert property (@(posedge clk) disable iff (rst)
        start |=> (!out_valid && lane_v == '0 && rec_v == '0));

endmodule

// File: tb/tb_csqrt_postscale.sv
module tb_csqrt_postscale;
    localparam int LOG_R = 2;
    localparam int A     = 3;
    localparam int CF    = 12;
    localparam int R     = 1 << LOG_R;
    localparam int CW    = CF + 1;
    localparam int SW    = $clog2(A + 1) + 1;
    localparam int OW    = LOG_R + 1;
    localparam int NSTEP = 14;
    localparam longint TOL = longint'(R) * R * (longint'(1) << CF);

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, dig_valid = 1'b0;
    logic signed [CW-1:0] cr_in = '0, ci_in = '0;
    logic signed [SW-1:0] dig_re = '0, dig_im = '0;
    logic out_valid;
    logic signed [OW-1:0] out_re, out_im;

    always #10 clk = ~clk;

    csqrt_postscale #(.LOG_R(LOG_R), .A(A), .CF(CF)) dut (
        .clk(clk), .rst(rst), .start(start), .cr_in(cr_in), .ci_in(ci_in),
        .dig_valid(dig_valid), .dig_re(dig_re), .dig_im(dig_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    typedef struct {
        longint er;
        longint ei;
        string  tag_r;
        string  tag_i;
    } exp_t;

    exp_t   sb_q[$];
    longint lat_q[$];
    longint cyc = 0;
    bit     dropping = 1'b0;
    int     n_tests = 0, n_fail = 0;
    longint vr = 0, vi = 0;
    int     cnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (dropping) begin
            vr = 0; vi = 0; cnt = 0;
        end else if (!rst && out_valid) begin
            if (lat_q.size() == 0) chk(1'b0, "R3 unexpected output", cyc, -1);
            else begin
                longint e;
                e = lat_q.pop_front();
                chk(cyc == e, "R3 output cycle", cyc, e);
            end
            chk(int'(out_re) >= -(R-1) && int'(out_re) <= R-1, "R4 real digit", out_re, R-1);
            chk(int'(out_im) >= -(R-1) && int'(out_im) <= R-1, "R4 imag digit", out_im, R-1);
            vr = vr * R + longint'(out_re);
            vi = vi * R + longint'(out_im);
            cnt++;
            if (cnt == NSTEP) begin
                if (sb_q.size() == 0) chk(1'b0, "R3 no expected result", vr, 0);
                else begin
                    exp_t x;
                    longint ar, ai;
                    x  = sb_q.pop_front();
                    ar = vr * R * R * (longint'(1) << CF);
                    ai = vi * R * R * (longint'(1) << CF);
                    chk((ar - x.er < TOL) && (x.er - ar < TOL), x.tag_r, ar, x.er);
                    chk((ai - x.ei < TOL) && (x.ei - ai < TOL), x.tag_i, ai, x.ei);
                end
                vr = 0; vi = 0; cnt = 0;
            end
        end
    end

    function automatic longint wsum(input int d[NSTEP]);
        longint s = 0;
        for (int k = 0; k < NSTEP; k++) s = s * R + d[k];
        return s;
    endfunction

    task automatic run_txn(input longint c_r, input longint c_i, input int dr[NSTEP],
                           input int di[NSTEP], input int gap, input string tr, input string ti);
        exp_t x;
        longint sr, si;
        sr = wsum(dr);
        si = wsum(di);
        x.er = c_r * sr - c_i * si;
        x.ei = c_r * si + c_i * sr;
        x.tag_r = tr;
        x.tag_i = ti;
        @(negedge clk);
        start = 1'b1; cr_in = CW'(c_r); ci_in = CW'(c_i); dig_valid = 1'b0;
        @(negedge clk);
        start = 1'b0; dropping = 1'b0;
        sb_q.push_back(x);
        for (int k = 0; k < NSTEP; k++) begin
            dig_re = SW'(dr[k]); dig_im = SW'(di[k]); dig_valid = 1'b1;
            lat_q.push_back(cyc + 3);
            @(negedge clk);
            if (gap > 0) begin
                dig_valid = 1'b0;
                repeat (gap) @(negedge clk);
            end
        end
        dig_valid = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    // Starts an operation and leaves digits in flight for the next start to kill
    task automatic abort_pre(input int n);
        @(negedge clk);
        start = 1'b1; cr_in = CW'(-4096); ci_in = CW'(4095); dig_valid = 1'b0;
        @(negedge clk);
        start = 1'b0; dropping = 1'b1;
        for (int k = 0; k < n; k++) begin
            dig_re = SW'(3); dig_im = SW'(-3); dig_valid = 1'b1;
            @(negedge clk);
        end
    endtask

    initial begin
        #4000000;
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int dr[NSTEP];
        int di[NSTEP];
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_re == 0 && out_im == 0, "R1 reset outputs",
            {out_valid, out_re, out_im}, 0);

        // R2: strobes before any start are ignored
        dig_re = SW'(3); dig_im = SW'(2); dig_valid = 1'b1;
        repeat (4) @(negedge clk);
        dig_valid = 1'b0;
        for (int k = 0; k < 6; k++) begin
            chk(out_valid == 1'b0, "R2 idle output", out_valid, 0);
            @(negedge clk);
        end

        // R5/R6: real-only factor, unit digits
        for (int k = 0; k < NSTEP; k++) begin dr[k] = (k < 8) ? 1 : 0; di[k] = 0; end
        run_txn(2048, 0, dr, di, 0, "R5 real value", "R6 imag value");

        // R5/R6: extreme factor, extreme alternating digits
        for (int k = 0; k < NSTEP; k++) begin
            dr[k] = (k < 8) ? ((k % 2) ? -3 : 3) : 0;
            di[k] = (k < 8) ? ((k % 2) ? 3 : -3) : 0;
        end
        run_txn(4095, 4095, dr, di, 0, "R5 real extreme", "R6 imag extreme");

        // R5/R6: factor of -1 on the imaginary part, full digit stream
        for (int k = 0; k < NSTEP; k++) begin dr[k] = -3; di[k] = 2; end
        run_txn(0, -4096, dr, di, 0, "R5 real minus one", "R6 imag minus one");

        // R8: mixed pattern with strobe gaps
        for (int k = 0; k < NSTEP; k++) begin
            dr[k] = (k < 8) ? ((k * 5 + 1) % 7) - 3 : 0;
            di[k] = (k < 8) ? ((k * 3 + 2) % 7) - 3 : 0;
        end
        run_txn(-4095, 1234, dr, di, 2, "R8 real with gaps", "R8 imag with gaps");
        run_txn(-4095, 1234, dr, di, 0, "R5 real no gaps", "R6 imag no gaps");

        // R7: restart while digits are in flight
        abort_pre(5);
        for (int k = 0; k < NSTEP; k++) begin
            dr[k] = (k < 8) ? ((k * 2 + 3) % 7) - 3 : 0;
            di[k] = (k < 8) ? ((k * 4 + 5) % 7) - 3 : 0;
        end
        run_txn(-700, -3001, dr, di, 0, "R7 real after restart", "R7 imag after restart");

        repeat (6) @(negedge clk);
        chk(sb_q.size() == 0, "R3 results outstanding", sb_q.size(), 0);
        chk(lat_q.size() == 0, "R3 digits outstanding", lat_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule